// File: doc/BRIEF.md
# Trace Stream Frame Formatter

This block packs a byte-wide trace stream, in which every byte is tagged with a 7-bit source identifier, into fixed 16-byte frames ready for a trace port. When the tag changes, the block inserts an identifier marker into the frame. It also moves bit 0 of each data byte that lands in a dual-purpose position into a trailing auxiliary byte. A downstream serializer takes completed frames one byte at a time, in transmit order, through a valid/ready handshake.

Frames are assembled in a 16-byte buffer and sent whole. Input is stalled while a completed frame drains. A flush request closes a partly filled frame: the block switches the stream to the reserved null identifier 0x00 and fills the remaining positions with zero data. A decoder that walks each frame from position 0 upward, applying the auxiliary bits, recovers the original (identifier, byte) sequence exactly.

Top module: `trace_frame_packer`

## Requirements
- R1: Every frame is exactly 16 bytes, emitted in position order 0..15. Even positions 0,2,..,14 are dual-purpose bytes, odd positions 1..13 hold whole data bytes, and position 15 is the auxiliary byte.
- R2: A dual-purpose byte holding data carries data bits 7:1 in its bits 7:1 and 0 in bit 0. Bit k of the auxiliary byte (for position 2k) carries that data byte's bit 0.
- R3: A dual-purpose byte holding an identifier marker is {id[6:0], 1}. If the identifier changes while the next free position is even, the marker goes there with auxiliary bit 1 (new identifier applies from the next data byte), and the byte follows in the next position.
- R4: If the identifier changes while the next free position p is odd, position p-1 is rewritten as the marker with auxiliary bit 0 (the next data byte still belongs to the old identifier). The old byte from p-1 moves whole into p, and the new byte goes into p+1 as data.
- R5: If the identifier changes when only position 14 is free, the marker takes position 14 with auxiliary bit 1. The byte is not accepted that cycle, and it enters the next frame at position 0 as data.
- R6: After reset out_valid is 0, in_ready is 1, and the current identifier is the null value 0x00, so the first accepted byte always produces a marker.
- R7: A flush on a partly filled frame stalls input, pads the frame as if zero bytes tagged 0x00 arrived (placing a marker for 0x00 by the rules of R3/R4 when the identifier was not already 0x00), and sends the frame.
- R8: A flush while the frame buffer is empty and not draining has no effect: no frame is produced and in_ready stays 1.
- R9: While a completed frame is being sent, in_ready is 0. While out_valid is 1 and out_ready is 0, out_valid and out_data hold.
- R10: Decoding the output frames recovers every accepted (identifier, byte) pair in order, with only zero data under identifier 0x00 added.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input byte offered |
| in_ready | output | 1 | Input byte accepted when high with in_valid |
| in_data | input | 8 | Trace data byte |
| in_id | input | 7 | Source identifier of the byte (0x00 reserved) |
| flush | input | 1 | Request to pad and close the current frame |
| out_valid | output | 1 | Frame byte available |
| out_ready | input | 1 | Downstream takes the frame byte |
| out_data | output | 8 | Frame byte, position order 0..15 |

## Verification
The assertions assume that upstream never tags a real byte with the null identifier 0x00 and that in_valid, in_id and in_data stay put until a byte is accepted. The stimulus draws identifiers only from a nonzero set and holds each offered byte until in_ready is sampled high. Flush pulses are driven only between offered bytes, never while a byte is waiting. The ready hold assertion relies on nothing writing the buffer while it is full, which the stall on the input side guarantees.

// File: rtl/trace_frame_packer.sv
`timescale 1ns/1ps
module trace_frame_packer (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  output logic       in_ready,
  input  logic [7:0] in_data,
  input  logic [6:0] in_id,
  input  logic       flush,
  output logic       out_valid,
  input  logic       out_ready,
  output logic [7:0] out_data
);
  localparam logic [3:0] LAST = 4'd15;
  localparam logic [3:0] TAIL = 4'd14;

  logic [7:0]  slot_q [16];
  logic [15:0] is_id_q;
  logic [3:0]  wp_q, rd_q;
  logic [6:0]  cur_id_q;
  logic        pad_q;
  logic [7:0]  aux;

  wire       full      = (wp_q == LAST);
  wire [6:0] src_id    = pad_q ? 7'd0 : in_id;
  wire [7:0] src_data  = pad_q ? 8'd0 : in_data;
  wire       change    = (src_id != cur_id_q);
  wire       tail_mark = change && (wp_q == TAIL);
  wire [3:0] wp_prev   = wp_q - 4'd1;
  wire [3:0] wp_next   = wp_q + 4'd1;

  assign in_ready = !full && !pad_q && !flush && !tail_mark;
  wire take      = pad_q ? !full : (in_valid && in_ready);
  wire mark_only = !full && tail_mark && (pad_q || (in_valid && !flush));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp_q     <= '0;
      rd_q     <= '0;
      cur_id_q <= '0;
      pad_q    <= 1'b0;
      is_id_q  <= '0;
    end else begin
      if (flush && !full && !pad_q && wp_q != 4'd0) pad_q <= 1'b1;
      if (pad_q && full) pad_q <= 1'b0;
      if (mark_only) begin
        slot_q[TAIL]  <= {src_id, 1'b1};
        is_id_q[TAIL] <= 1'b1;
        cur_id_q      <= src_id;
        wp_q          <= LAST;
      end else if (take) begin
        cur_id_q <= src_id;
        if (!change) begin
          slot_q[wp_q]  <= src_data;
          is_id_q[wp_q] <= 1'b0;
          wp_q          <= wp_next;
        end else if (!wp_q[0]) begin
          slot_q[wp_q]     <= {src_id, 1'b1};
          is_id_q[wp_q]    <= 1'b1;
          slot_q[wp_next]  <= src_data;
          is_id_q[wp_next] <= 1'b0;
          wp_q             <= wp_q + 4'd2;
        end else begin
          slot_q[wp_prev]  <= {src_id, 1'b0};
          is_id_q[wp_prev] <= 1'b1;
          slot_q[wp_q]     <= slot_q[wp_prev];
          is_id_q[wp_q]    <= 1'b0;
          slot_q[wp_next]  <= src_data;
          is_id_q[wp_next] <= 1'b0;
          wp_q             <= wp_q + 4'd2;
        end
      end
      if (out_valid && out_ready) begin
        rd_q <= rd_q + 4'd1;
        if (rd_q == LAST) wp_q <= '0;
      end
    end
  end

  always_comb begin
    for (int k = 0; k < 8; k++) aux[k] = slot_q[2*k][0];
  end

  assign out_valid = full;
  assign out_data  = (rd_q == LAST) ? aux :
                     (!rd_q[0] ? {slot_q[rd_q][7:1], is_id_q[rd_q]} : slot_q[rd_q]);

  a_r9_no_accept_when_full: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !in_ready);

  a_r9_hold_output: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data));

  a_r1_frame_closes: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && rd_q == LAST |=> !out_valid && rd_q == 4'd0);

  a_r7_pad_progress: assert property (@(posedge clk) disable iff (!rst_n)
    pad_q && !full |=> wp_q != $past(wp_q));

  a_r5_tail_marker: assert property (@(posedge clk) disable iff (!rst_n)
    mark_only |=> out_valid && is_id_q[TAIL] && slot_q[TAIL][0]);
endmodule

// File: tb/tb_trace_frame_packer.sv
`timescale 1ns/1ps
module tb_trace_frame_packer;
  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0, in_ready, flush = 1'b0, out_valid, out_ready;
  logic [7:0] in_data = '0, out_data;
  logic [6:0] in_id = '0;
  int rdy_mode = 1;
  int n_chk = 0, n_fail = 0;

  logic [14:0] sent [$];
  logic [15:0][7:0] frames [$];
  logic [15:0][7:0] fb;
  int fcnt = 0;
  logic [6:0] dec_cur = '0, dec_pend = '0;
  bit dec_pv = 1'b0;

  always #2.5 clk = ~clk;

  trace_frame_packer dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_id(in_id), .flush(flush),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  function automatic logic [7:0] marker(input logic [6:0] id);
    return {id, 1'b1};
  endfunction

  function automatic logic [7:0] mixed_data(input logic [7:0] d);
    return {d[7:1], 1'b0};
  endfunction

  task automatic emit(input logic [6:0] id, input logic [7:0] d);
    if (id == 7'd0) chk("R10 pad data zero", d, 8'd0);
    else if (sent.size() == 0) chk("R10 unexpected byte", {id, d}, 15'h0);
    else begin
      chk("R10 round trip", {id, d}, sent[0]);
      void'(sent.pop_front());
    end
    if (dec_pv) begin dec_cur = dec_pend; dec_pv = 1'b0; end
  endtask

  task automatic decode(input logic [15:0][7:0] f);
    for (int k = 0; k < 8; k++) begin
      logic [7:0] b;
      logic a;
      b = f[2*k];
      a = f[15][k];
      if (b[0]) begin
        if (a) begin dec_cur = b[7:1]; dec_pv = 1'b0; end
        else begin dec_pend = b[7:1]; dec_pv = 1'b1; end
      end else emit(dec_cur, {b[7:1], a});
      if (k < 7) emit(dec_cur, f[2*k+1]);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (in_valid && in_ready) sent.push_back({in_id, in_data});
      if (out_valid && out_ready) begin
        fb[fcnt] = out_data;
        fcnt++;
        if (fcnt == 16) begin
          fcnt = 0;
          frames.push_back(fb);
          decode(fb);
        end
      end
    end
  end

  initial begin
    out_ready = 1'b1;
    forever begin
      @(posedge clk); #1;
      if (rdy_mode == 0) out_ready = 1'b0;
      else if (rdy_mode == 1) out_ready = 1'b1;
      else out_ready = ($urandom % 4) != 0;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    summary();
  end

  task automatic send(input logic [6:0] id, input logic [7:0] d);
    logic acc;
    in_valid = 1'b1; in_id = id; in_data = d;
    do begin
      @(negedge clk); acc = in_ready;
      @(posedge clk); #1;
    end while (!acc);
    in_valid = 1'b0;
  endtask

  task automatic pulse_flush();
    flush = 1'b1;
    @(posedge clk); #1;
    flush = 1'b0;
  endtask

  task automatic wait_frames(input int n);
    while (frames.size() < n) begin @(posedge clk); #1; end
  endtask

  initial begin
    logic [15:0][7:0] f;
    int nf;
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk("R6 out_valid after reset", out_valid, 1'b0);
    chk("R6 in_ready after reset", in_ready, 1'b1);
    @(posedge clk); #1;

    // R1 R2 R3 R6: plain frame, first byte forces a marker
    nf = frames.size();
    for (int i = 0; i < 14; i++) send(7'd5, 8'hA0 + 8'(i));
    wait_frames(nf + 1);
    f = frames[nf];
    chk("R6 R3 first marker", f[0], marker(7'd5));
    chk("R1 odd slot whole byte", f[1], 8'hA0);
    chk("R2 mixed data slot", f[2], mixed_data(8'hA1));
    chk("R2 last mixed slot", f[14], mixed_data(8'hAD));
    chk("R2 R3 aux byte", f[15], 8'hFF);

    // R4 R7: change on odd slot, then flush
    nf = frames.size();
    send(7'd5, 8'h11);
    send(7'd6, 8'h22);
    pulse_flush();
    wait_frames(nf + 1);
    f = frames[nf];
    chk("R4 rewritten marker", f[0], marker(7'd6));
    chk("R4 moved old byte", f[1], 8'h11);
    chk("R7 null marker", f[2], marker(7'd0));
    chk("R4 R7 new byte moved", f[3], 8'h22);
    chk("R7 zero fill", f[9], 8'h00);
    chk("R4 aux bits zero", f[15], 8'h00);

    // R5: change with only slot 14 free
    nf = frames.size();
    send(7'd7, 8'h30);
    for (int i = 1; i < 13; i++) send(7'd7, 8'h30 + 8'(i));
    send(7'd9, 8'h5A);
    pulse_flush();
    wait_frames(nf + 2);
    f = frames[nf];
    chk("R5 tail marker", f[14], marker(7'd9));
    chk("R5 tail aux bit", f[15][7], 1'b1);
    f = frames[nf + 1];
    chk("R5 R7 carried byte marker", f[0], marker(7'd0));
    chk("R5 carried byte", f[1], 8'h5A);
    chk("R5 carried aux bit", f[15][0], 1'b0);

    // R9: backpressure
    rdy_mode = 0;
    @(posedge clk); #1;
    nf = frames.size();
    for (int i = 0; i < 14; i++) send(7'd3, 8'(i));
    @(negedge clk);
    chk("R9 out_valid when full", out_valid, 1'b1);
    chk("R9 first byte", out_data, marker(7'd3));
    chk("R9 in_ready low when full", in_ready, 1'b0);
    repeat (4) @(negedge clk);
    chk("R9 held valid", out_valid, 1'b1);
    chk("R9 held data", out_data, marker(7'd3));
    rdy_mode = 1;
    wait_frames(nf + 1);

    // R8: flush on empty buffer
    @(posedge clk); #1;
    nf = frames.size();
    pulse_flush();
    repeat (10) @(negedge clk);
    chk("R8 no frame", out_valid, 1'b0);
    chk("R8 ready stays", in_ready, 1'b1);
    chk("R8 frame count", frames.size(), nf);
    @(posedge clk); #1;

    // R10: random traffic
    rdy_mode = 2;
    for (int i = 0; i < 400; i++) begin
      logic [6:0] id;
      case ($urandom % 4)
        0: id = 7'd1;
        1: id = 7'd2;
        2: id = 7'd3;
        default: id = 7'h45;
      endcase
      if (($urandom % 3) != 0) id = in_id == 7'd0 ? 7'd1 : in_id;
      send(id, 8'($urandom));
      repeat ($urandom % 3) begin @(posedge clk); #1; end
      if (($urandom % 32) == 0) pulse_flush();
    end
    pulse_flush();
    repeat (300) begin @(posedge clk); #1; end
    chk("R10 all bytes recovered", sent.size(), 0);
    chk("R1 no partial frame", fcnt, 0);
    summary();
  end
endmodule